// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This unit turns the operand fields of a small 8-bit controller's data-memory instructions into a 12-bit byte address. It also serves the access itself, reading and writing a byte-wide store. The address has three possible sources:

- **Direct.** The 8-bit operand is the offset, and the bank comes from a bank register held inside the unit.
- **Access window.** This mapping ignores the bank register. The lower half of the operand range lands at the bottom of bank 0, and the upper half lands on the peripheral register window at the top of bank 15.
- **Indirect.** A full 12-bit pointer reaches any location without any banking.

General purpose RAM fills the space upward from address 000h, up to a size set by a parameter. Peripheral registers sit from F80h to FFFh and are modelled as a plain register array. Everything between the top of the RAM and F80h is unimplemented: reads there return zero and writes there are discarded.

Reads are combinational from the address formed in the same cycle. Writes land on the rising clock edge. The RAM keeps its contents through reset.

Top module: `dmem_addr_unit`

## Requirements
- R1: When `ind_sel` and `acc_sel` are both low, `eff_addr` is the bank register's low nibble (bits 11:8) concatenated with `op_addr` (bits 7:0).
- R2: The bank register resets to 00h. A write through `bank_we` stores only `bank_wdata[3:0]`. Bits 7:4 of `bank_q` always read 0.
- R3: With `acc_sel` high and `ind_sel` low:
  - operand 00h–7Fh maps to 000h–07Fh;
  - operand 80h–FFh maps to F80h–FFFh;
  - the bank register has no effect on the address.
- R4: With `ind_sel` high, `eff_addr` equals `ptr`, regardless of `acc_sel` and the bank register.
- R5: Addresses 000h up to `GPR_BYTES`-1 (default 512) are RAM. A write with `wr_en` high is stored at the rising edge, and `rd_data` shows the byte at `eff_addr` in the same cycle.
- R6: Addresses F80h–FFFh raise `sfr_hit` and read and write a 128-entry register array.
- R7: Addresses from `GPR_BYTES` to F7Fh raise `unimpl`. Reads there return 00h. Writes there change no location anywhere.
- R8: Asserting reset leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset (bank register only) |
| op_addr | input | 8 | File operand offset |
| acc_sel | input | 1 | Select the access-window mapping |
| ind_sel | input | 1 | Select the indirect pointer |
| ptr | input | 12 | Indirect pointer address |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 8 | Bank register write data |
| bank_q | output | 8 | Bank register read value |
| wr_en | input | 1 | Data write enable |
| wr_data | input | 8 | Data write byte |
| rd_data | output | 8 | Data read byte |
| eff_addr | output | 12 | Effective address |
| sfr_hit | output | 1 | Address in peripheral window |
| unimpl | output | 1 | Address unimplemented |

## Verification
A wrong bank value or a wrong mapping choice shows up at `eff_addr` in the same cycle, without waiting for any access. The bench compares that port against its own address model for every source.

A bad region decode or a truncated RAM index is exposed differently. A write to unimplemented space would alias onto low RAM, so the next read of that low location returns the stray byte one cycle after the write. A reset that clobbers the RAM is seen on the first read after reset is released.

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit #(
  parameter int GPR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  op_addr,
  input  logic        acc_sel,
  input  logic        ind_sel,
  input  logic [11:0] ptr,
  input  logic        bank_we,
  input  logic [7:0]  bank_wdata,
  output logic [7:0]  bank_q,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic [11:0] eff_addr,
  output logic        sfr_hit,
  output logic        unimpl
);
  localparam int          GA_W    = $clog2(GPR_BYTES);
  localparam logic [11:0] GPR_TOP = 12'(GPR_BYTES);

  logic [3:0] bank;
  logic [7:0] gpr [GPR_BYTES];
  logic [7:0] sfr [128];
  logic       gpr_hit;
  logic [11:0] acc_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bank <= 4'h0;
    else if (bank_we) bank <= bank_wdata[3:0];

  assign bank_q   = {4'h0, bank};
  assign acc_addr = op_addr[7] ? {4'hF, op_addr} : {4'h0, op_addr};
  assign eff_addr = ind_sel ? ptr : (acc_sel ? acc_addr : {bank, op_addr});

  assign sfr_hit = eff_addr[11:7] == 5'h1F;
  assign gpr_hit = eff_addr < GPR_TOP;
  assign unimpl  = !sfr_hit && !gpr_hit;

  always_ff @(posedge clk) begin
    if (wr_en && gpr_hit) gpr[eff_addr[GA_W-1:0]] <= wr_data;
    if (wr_en && sfr_hit) sfr[eff_addr[6:0]] <= wr_data;
  end

  assign rd_data = sfr_hit ? sfr[eff_addr[6:0]] :
                   gpr_hit ? gpr[eff_addr[GA_W-1:0]] : 8'h00;

  p_direct_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ind_sel && !acc_sel) |-> (eff_addr[11:8] == bank_q[3:0] && eff_addr[7:0] == op_addr));
  p_bank_low_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> bank_q == {4'h0, $past(bank_wdata[3:0])});
  p_access_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel && !ind_sel) |-> (eff_addr[7:0] == op_addr &&
      (eff_addr[11:8] == 4'h0 || eff_addr[11:8] == 4'hF)));
  p_indirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ind_sel |-> eff_addr == ptr);
  p_write_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unimpl) |=> ($stable(eff_addr) -> rd_data == $past(wr_data)));
  p_region_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sfr_hit, unimpl}));
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl |-> rd_data == 8'h00);
endmodule

// File: tb/dmem_addr_unit_tb.sv
module dmem_addr_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  op_addr = 0, bank_wdata = 0, wr_data = 0;
  logic        acc_sel = 0, ind_sel = 0, bank_we = 0, wr_en = 0;
  logic [11:0] ptr = 0;
  logic [7:0]  bank_q, rd_data;
  logic [11:0] eff_addr;
  logic        sfr_hit, unimpl;
  int errors = 0, checks = 0;
  logic [3:0] ref_bank = 0;

  always #10 clk = ~clk;

  dmem_addr_unit #(.GPR_BYTES(512)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .acc_sel(acc_sel), .ind_sel(ind_sel),
    .ptr(ptr), .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_q(bank_q),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .eff_addr(eff_addr),
    .sfr_hit(sfr_hit), .unimpl(unimpl));

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_addr(logic ind, logic acc, logic [7:0] op, logic [11:0] p);
    if (ind) return p;
    if (acc) return (op < 8'h80) ? {4'h0, op} : {4'hF, op};
    return {ref_bank, op};
  endfunction

  task automatic set_bank(logic [7:0] v);
    @(negedge clk); bank_we = 1; bank_wdata = v;
    @(negedge clk); bank_we = 0;
    ref_bank = v[3:0];
  endtask

  task automatic point(logic ind, logic acc, logic [7:0] op, logic [11:0] p);
    @(negedge clk); ind_sel = ind; acc_sel = acc; op_addr = op; ptr = p; #1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; #1;
  endtask

  task automatic t_reset_state;
    chk("R2 reset bank", {4'h0, bank_q}, 12'h000);
  endtask

  task automatic t_bank_reg;
    set_bank(8'hA5); #1;
    chk("R2 upper bits", {4'h0, bank_q}, 12'h005);
  endtask

  task automatic t_direct;
    set_bank(8'h01);
    point(0, 0, 8'h23, 12'h0); chk("R1 direct", eff_addr, ref_addr(0, 0, 8'h23, 0));
    wr(8'h5A); chk("R5 gpr readback", {4'h0, rd_data}, 12'h05A);
    set_bank(8'h07);
    point(0, 0, 8'hC4, 12'h0); chk("R1 direct bank7", eff_addr, ref_addr(0, 0, 8'hC4, 0));
    chk("R7 bank7 unimpl", {11'h0, unimpl}, 12'h001);
  endtask

  task automatic t_access;
    set_bank(8'h03);
    point(0, 1, 8'h10, 12'h0); chk("R3 access low", eff_addr, ref_addr(0, 1, 8'h10, 0));
    point(0, 1, 8'h7F, 12'h0); chk("R3 access edge", eff_addr, 12'h07F);
    point(0, 1, 8'h80, 12'h0); chk("R3 access high", eff_addr, 12'hF80);
    chk("R6 sfr_hit", {11'h0, sfr_hit}, 12'h001);
  endtask

  task automatic t_indirect;
    point(1, 1, 8'h10, 12'h1FF); chk("R4 indirect", eff_addr, 12'h1FF);
    wr(8'hC3);
    set_bank(8'h01);
    point(0, 0, 8'hFF, 12'h0); chk("R4 ind write seen direct", {4'h0, rd_data}, 12'h0C3);
  endtask

  task automatic t_sfr;
    point(1, 0, 8'h00, 12'hFC0); wr(8'h3C);
    point(0, 1, 8'hC0, 12'h0); chk("R6 sfr readback", {4'h0, rd_data}, 12'h03C);
  endtask

  task automatic t_unimpl;
    point(1, 0, 8'h0, 12'h000); wr(8'h11);
    point(1, 0, 8'h0, 12'h200); chk("R7 unimpl flag", {11'h0, unimpl}, 12'h001);
    wr(8'h77); chk("R7 unimpl read", {4'h0, rd_data}, 12'h000);
    point(1, 0, 8'h0, 12'h000); chk("R7 no alias", {4'h0, rd_data}, 12'h011);
    point(1, 0, 8'h0, 12'hF7F); wr(8'h66);
    chk("R7 top unimpl read", {4'h0, rd_data}, 12'h000);
    point(1, 0, 8'h0, 12'hFFF); chk("R7 sfr not top", {11'h0, unimpl}, 12'h000);
  endtask

  task automatic t_reset_keep;
    point(1, 0, 8'h0, 12'h055); wr(8'hAB);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; ref_bank = 0; #1;
    chk("R8 ram kept", {4'h0, rd_data}, 12'h0AB);
    chk("R2 bank after reset", {4'h0, bank_q}, 12'h000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        t_reset_state; t_bank_reg; t_direct; t_access;
        t_indirect; t_sfr; t_unimpl; t_reset_keep;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule